// File: doc/BRIEF.md
# Word Shifter With Status Flags

A combinational shift stage for a 16-bit datapath. It takes an operand word, a raw count byte and an operation code, and returns the shifted word, a write strobe and a fresh six-bit status vector. The three operations are logical left, logical right and arithmetic right. Counts run from 1 to 31, so the unit has to give defined results for counts equal to or larger than the operand width.

A count of zero after masking is treated as "no instruction effect". The write strobe stays low, the operand passes through unchanged, and the incoming status vector is returned untouched. The surrounding pipeline can therefore always commit `flags_out` without needing a separate flag-enable path.

Top module: `shift16_flags`

## Requirements
- R1: Only the five low bits of `cnt_raw` form the count; bits 7:5 have no effect on any output.
- R2: With a masked count of zero, `wr_en` is 0, `result` equals `opnd` and `flags_out` equals `flags_in`.
- R3: Left shift (op_sel 2'b00) with count 1..16: result = opnd << count, CF = opnd bit (16-count), OF = CF xor result[15].
- R4: Left shift with count 17..31: result is 0, and CF and OF are both 0.
- R5: Logical right shift (op_sel 2'b01): result = opnd >> count, CF = opnd bit (count-1), which reads as 0 for counts above 16, and OF = result[15] xor result[14].
- R6: Arithmetic right shift (op_sel 2'b10): the sign bit fills the vacated positions, CF = bit (count-1) of the sign-extended operand, and OF = 0.
- R7: For a nonzero count, SF = result[15], ZF = 1 exactly when result is zero, and PF = 1 when result[7:0] holds an even number of ones.
- R8: AF is 0 after every nonzero-count shift, and `wr_en` is 1.
- R9: op_sel 2'b11 is a no-op that behaves as in R2 whatever the count.
- R10: Status bit positions in both `flags_in` and `flags_out` are: [0] CF, [1] PF, [2] AF, [3] ZF, [4] SF, [5] OF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd | input | 16 | Operand word |
| cnt_raw | input | 8 | Raw count; only low five bits used |
| op_sel | input | 2 | 00 left, 01 logical right, 10 arithmetic right, 11 none |
| flags_in | input | 6 | Current status vector |
| result | output | 16 | Shifted word |
| wr_en | output | 1 | High when the result must be written back |
| flags_out | output | 6 | Updated status vector |

## Verification
The bench builds the unit with its default 16-bit width and 5-bit count field. Because the mask is wider than the log of the width, the 32 count codes span zero, the in-range shifts, the exact-width shift of 16 and the beyond-width shifts 17 to 31, which are all swept for every operation. Sign-edge operands 0x8000 and 0x7FFF are among the swept values. Random operands, upper count bits and input flags are then mixed in.

// File: rtl/shift16_flags.sv
module shift16_flags #(
  parameter int W  = 16,
  parameter int CW = 5
) (
  input  logic [W-1:0] opnd,
  input  logic [7:0]   cnt_raw,
  input  logic [1:0]   op_sel,
  input  logic [5:0]   flags_in,
  output logic [W-1:0] result,
  output logic         wr_en,
  output logic [5:0]   flags_out
);
  localparam int DW = 2 * W;
  localparam logic [1:0] OP_SHL = 2'b00;
  localparam logic [1:0] OP_SHR = 2'b01;
  localparam logic [1:0] OP_SAR = 2'b10;

  logic [CW-1:0] cnt;
  logic [DW-1:0] lft, rgt, ars;
  logic [W-1:0]  res;
  logic          cf, of, act;

  assign cnt = cnt_raw[CW-1:0];
  assign act = (cnt != '0) && (op_sel != 2'b11);

  assign lft = {{W{1'b0}}, opnd} << cnt;
  assign rgt = {opnd, {W{1'b0}}} >> cnt;
  assign ars = $signed({opnd, {W{1'b0}}}) >>> cnt;

  always_comb begin
    res = opnd;
    cf  = 1'b0;
    of  = 1'b0;
    case (op_sel)
      OP_SHL: begin
        res = lft[W-1:0];
        cf  = lft[W];
        of  = lft[W] ^ lft[W-1];
      end
      OP_SHR: begin
        res = rgt[DW-1:W];
        cf  = rgt[W-1];
        of  = rgt[DW-1] ^ rgt[DW-2];
      end
      OP_SAR: begin
        res = ars[DW-1:W];
        cf  = ars[W-1];
      end
      default: ;
    endcase
  end

  assign result    = act ? res : opnd;
  assign wr_en     = act;
  assign flags_out = act ? {of, res[W-1], res == '0, 1'b0, ~^res[7:0], cf} : flags_in;

  always_comb begin
    if (!act) AST_IDLE_PASSTHRU: assert (!wr_en && result == opnd && flags_out == flags_in); // R2
    if (op_sel == OP_SHL && cnt > CW'(W)) AST_WIDE_LEFT_CLEARS: assert (result == '0 && flags_out[0] == 1'b0 && flags_out[5] == 1'b0); // R4
    if (act && op_sel == OP_SHR) AST_SHR_TOP_ZERO: assert (result[W-1] == 1'b0); // R5
    if (act && op_sel == OP_SAR) AST_SAR_KEEPS_SIGN: assert (result[W-1] == opnd[W-1] && flags_out[5] == 1'b0); // R6
    if (act) AST_AUX_CLEAR: assert (flags_out[2] == 1'b0 && wr_en); // R8
    if (op_sel == 2'b11) AST_SPARE_OP_IDLE: assert (!wr_en); // R9
  end
endmodule

// File: tb/test_shift16_flags.sv
module test_shift16_flags;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [15:0] opnd;
  logic [7:0]  cnt_raw;
  logic [1:0]  op_sel;
  logic [5:0]  flags_in;
  logic [15:0] result;
  logic        wr_en;
  logic [5:0]  flags_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  shift16_flags i_shift16_flags (
    .opnd(opnd), .cnt_raw(cnt_raw), .op_sel(op_sel), .flags_in(flags_in),
    .result(result), .wr_en(wr_en), .flags_out(flags_out)
  );

  // reference by repeated single-bit steps; returns {wr, result, flags}
  function automatic logic [22:0] model(input logic [15:0] v, input logic [7:0] c,
                                        input logic [1:0] op, input logic [5:0] fi);
    logic [15:0] x = v;
    logic cy = 1'b0;
    logic ov = 1'b0;
    int k = int'(c & 8'h1f);
    if (k == 0 || op == 2'b11) return {1'b0, v, fi};
    for (int s = 0; s < k; s++) begin
      if (op == 2'b00) begin cy = x[15]; x = {x[14:0], 1'b0}; end
      else if (op == 2'b01) begin cy = x[0]; x = {1'b0, x[15:1]}; end
      else begin cy = x[0]; x = {x[15], x[15:1]}; end
    end
    if (op == 2'b00) ov = (k <= 16) ? (cy ^ x[15]) : 1'b0;
    else if (op == 2'b01) ov = x[15] ^ x[14];
    else ov = 1'b0;
    return {1'b1, x, ov, x[15], (x == 16'h0), 1'b0, ~^x[7:0], cy};
  endfunction

  function automatic string tag_of(input logic [7:0] c, input logic [1:0] op);
    int k = int'(c & 8'h1f);
    if (op == 2'b11) return "R9";
    if (k == 0) return "R2";
    if (op == 2'b00) return (k <= 16) ? "R3" : "R4";
    if (op == 2'b01) return "R5";
    return "R6";
  endfunction

  task automatic apply(input logic [15:0] v, input logic [7:0] c,
                       input logic [1:0] op, input logic [5:0] fi, input string extra);
    logic [22:0] e;
    string t;
    @(negedge clk);
    opnd = v; cnt_raw = c; op_sel = op; flags_in = fi;
    #1;
    e = model(v, c, op, fi);
    t = tag_of(c, op);
    n_chk++;
    if (wr_en !== e[22] || result !== e[21:6]) begin
      n_bad++;
      $display("FAIL %s%s op=%0d cnt=%h opnd=%h: wr/result %b/%h expected %b/%h",
               t, extra, op, c, v, wr_en, result, e[22], e[21:6]);
    end
    n_chk++;
    if (flags_out[0] !== e[0] || flags_out[5] !== e[5]) begin
      n_bad++;
      $display("FAIL %s%s op=%0d cnt=%h opnd=%h: OF,CF %b%b expected %b%b",
               t, extra, op, c, v, flags_out[5], flags_out[0], e[5], e[0]);
    end
    n_chk++;
    if (flags_out[4:1] !== e[4:1]) begin
      n_bad++;
      $display("FAIL %s%s op=%0d cnt=%h opnd=%h: SF,ZF,AF,PF %b expected %b",
               e[22] ? "R7/R8/R10" : t, extra, op, c, v, flags_out[4:1], e[4:1]);
    end
  endtask

  initial begin
    #400000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] corner [4];
    void'($urandom(32'h5eed_0042));
    corner[0] = 16'h8000; corner[1] = 16'h7fff;
    corner[2] = 16'hffff; corner[3] = 16'h0001;
    opnd = '0; cnt_raw = '0; op_sel = '0; flags_in = '0;
    // reset-like idle state: zero count passes inputs through (R2)
    apply(16'h1234, 8'h00, 2'b00, 6'b101011, " idle");
    // R1: upper count bits ignored
    apply(16'hc3a5, 8'he0, 2'b01, 6'b010101, " R1");
    apply(16'hc3a5, 8'ha3, 2'b10, 6'b000000, " R1");
    apply(16'h8001, 8'h41, 2'b00, 6'b111111, " R1");
    // R9: spare code with nonzero count
    apply(16'hbeef, 8'h05, 2'b11, 6'b100110, "");
    // R4 boundary at exactly 16 vs 17, R7 zero/parity
    apply(16'h0001, 8'h10, 2'b00, 6'b000000, " R3 edge");
    apply(16'h0001, 8'h11, 2'b00, 6'b000000, " R4 edge");
    apply(16'h0003, 8'h02, 2'b01, 6'b000000, " R7 zero");
    for (int op = 0; op < 3; op++)
      for (int c = 0; c < 32; c++)
        for (int j = 0; j < 4; j++)
          apply(corner[j], 8'(c), 2'(op), 6'b101101, " sweep");
    for (int r = 0; r < 3000; r++)
      apply(16'($urandom), 8'($urandom), 2'($urandom), 6'($urandom), " R1 rand");
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule